// File: doc/BRIEF.md
# Framed synchronous serial receiver

This block is the receive engine of a synchronous serial port. It samples a frame sync line and a serial data line once per bit period, marked by a one-cycle bit-clock enable. An edge of the frame sync line opens a frame, and the user picks whether a rising or a falling edge counts. After a programmable delay the engine assembles a programmable number of words of programmable length, filling each word from the chosen end. It then goes idle and waits for the next start edge.

While a frame is in its delay phase, the engine can also capture a short synchronization tag. It does this only when the tag is no longer than the delay. The tag is collected in the same shift register as the data and then moved into its own holding register. A separately selected edge of the frame sync line sets a sticky status flag. This flag does not depend on whether a frame is running.

Completed words land in a holding register with a valid flag, which software clears with an acknowledge pulse. A word that arrives while the previous one is still unread sets a sticky overrun flag.

Top module: `frame_sync_rx`

## Requirements
- R1: The frame sync line is sampled only on bit ticks (`bclk_en`=1). An edge is a difference between the current sample and the previous tick's sample, and the previous sample is 0 after reset. A start edge (rising if `cfg_start_fall`=0, falling if 1) opens a frame and raises `busy` in the next cycle. A start edge seen while `busy`=1 is ignored.
- R2: With delay value D (`cfg_delay`), the first data bit is the `rd_in` sample taken on the (D+1)-th tick after the tick that detected the start edge. D=0 means the tick right after it.
- R3: A frame holds `cfg_nwords_m1`+1 words, each of `cfg_dlen_m1`+1 bits, sampled on consecutive ticks. `busy` drops in the cycle after the tick that delivers the last bit.
- R4: With `cfg_msb_first`=1, the first received bit of a word lands at bit position `cfg_dlen_m1` of `data_out`. With `cfg_msb_first`=0, it lands at bit 0. The word is right-aligned and its unused upper bits are 0.
- R5: Let L = `cfg_synclen_m1`+1. If L ≤ D, the samples on ticks 1..L after the start tick form the sync tag. The tag uses the bit order of R4, is right-aligned in `sync_tag`, and loads in the cycle after tick L, with `sync_tag_new` high for exactly that cycle. If L > D, `sync_tag` is left unchanged.
- R6: `sync_flag` is set after a tick on which the selected edge is seen (rising if `cfg_sync_fall`=0, falling if 1), whether or not a frame is running. It stays set until a `stat_clr` pulse clears it, and a set in the same cycle wins over the clear.
- R7: When a word completes, `data_valid` is set and `data_out` is loaded in the next cycle. `data_valid` stays high until a `data_ack` cycle in which no new word completes.
- R8: If a word completes while `data_valid`=1 and `data_ack`=0, `overrun` is set. It stays set until a `stat_clr` pulse clears it, and a set in the same cycle wins over the clear.
- R9: Synchronous active-high reset clears `busy`, `data_valid`, `data_out`, `sync_tag`, `sync_tag_new`, `sync_flag` and `overrun`.
- R10: In cycles without a bit tick, neither `busy` nor `data_out` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle bit tick |
| rf_in | input | 1 | Frame sync line |
| rd_in | input | 1 | Serial data line |
| cfg_start_fall | input | 1 | Start on falling edge when 1, rising when 0 |
| cfg_sync_fall | input | 1 | Status flag on falling edge when 1, rising when 0 |
| cfg_msb_first | input | 1 | Bit order of words and tag |
| cfg_delay | input | DLY_W | Ticks between start tick and first data bit |
| cfg_dlen_m1 | input | $clog2(DW) | Word length minus one |
| cfg_nwords_m1 | input | NW_W | Words per frame minus one |
| cfg_synclen_m1 | input | 4 | Sync tag length minus one |
| data_ack | input | 1 | Holding register read acknowledge |
| stat_clr | input | 1 | Clears sync_flag and overrun |
| data_out | output | DW | Received word |
| data_valid | output | 1 | Unread word present |
| sync_tag | output | 16 | Last captured sync tag |
| sync_tag_new | output | 1 | One-cycle pulse on tag load |
| sync_flag | output | 1 | Sticky sync edge flag |
| overrun | output | 1 | Sticky overrun flag |
| busy | output | 1 | Frame in progress |

## Verification
The hardest situation to reach is a start edge, or a sync-flag edge, arriving in the same tick as the final bit of a frame, or in the middle of a frame. The frame must ignore such a start edge, while the flag must still react. The stimulus reaches it by toggling the frame sync line at random ticks throughout long runs, so edges fall at every phase of a frame. It does this across five configurations that vary the tick spacing, delay, word length, word count and edge polarities. One configuration never acknowledges, to drive repeated overruns. Another makes the tag exactly as long as the delay, the edge of the capture condition.

// File: rtl/frame_sync_rx_pkg.sv
package frame_sync_rx_pkg;

    localparam int SYNC_MAX = 16;
    localparam int SL_W     = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_DATA  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic sync;
    } rf_evt_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsr_edge.sv
module fsr_edge
    import frame_sync_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    rf_in,
    input  logic    start_fall,
    input  logic    sync_fall,
    input  logic    stat_clr,
    output rf_evt_t evt,
    output logic    sync_flag
);
    logic rf_last;
    logic rise;
    logic fall;

    always_comb begin
        rise      = rf_in & ~rf_last;
        fall      = ~rf_in & rf_last;
        evt.start = tick & (start_fall ? fall : rise);
        evt.sync  = tick & (sync_fall ? fall : rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_last   <= 1'b0;
            sync_flag <= 1'b0;
        end else begin
            if (tick) rf_last <= rf_in;
            if (evt.sync)      sync_flag <= 1'b1;
            else if (stat_clr) sync_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/fsr_shift.sv
module fsr_shift #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    input  logic          msb_first,
    input  logic [IW-1:0] len_m1,
    input  logic          rd,
    output logic [W-1:0]  sh_next
);
    logic [W-1:0] sh;
    logic [W-1:0] base;

    always_comb begin
        base = clr ? '0 : sh;
        if (msb_first) begin
            sh_next = {base[W-2:0], rd};
        end else begin
            sh_next         = base >> 1;
            sh_next[len_m1] = rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     sh <= '0;
        else if (en) sh <= sh_next;
    end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import frame_sync_rx_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int LEN_W = 4,
    parameter int NW_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start_evt,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [LEN_W-1:0] cfg_dlen_m1,
    input  logic [NW_W-1:0]  cfg_nwords_m1,
    input  logic [SL_W-1:0]  cfg_synclen_m1,
    output logic             shift_en,
    output logic             shift_clr,
    output logic             phase_sync,
    output logic             tag_done,
    output logic             word_done,
    output logic             busy
);
    localparam int CW = max_int(DLY_W, LEN_W);

    rx_state_e         state, state_n;
    logic [CW-1:0]     bitcnt, bitcnt_n;
    logic [NW_W-1:0]   wordcnt, wordcnt_n;
    logic              sync_ok;

    assign sync_ok = (int'(cfg_synclen_m1) + 1) <= int'(cfg_delay);
    assign busy    = (state != ST_IDLE);

    always_comb begin
        state_n    = state;
        bitcnt_n   = bitcnt;
        wordcnt_n  = wordcnt;
        shift_en   = 1'b0;
        shift_clr  = 1'b0;
        phase_sync = 1'b0;
        tag_done   = 1'b0;
        word_done  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_evt) begin
                    state_n   = (cfg_delay == '0) ? ST_DATA : ST_DELAY;
                    bitcnt_n  = '0;
                    wordcnt_n = '0;
                end
            end
            ST_DELAY: begin
                if (tick) begin
                    if (sync_ok && bitcnt <= CW'(cfg_synclen_m1)) begin
                        shift_en   = 1'b1;
                        shift_clr  = (bitcnt == '0);
                        phase_sync = 1'b1;
                        tag_done   = (bitcnt == CW'(cfg_synclen_m1));
                    end
                    if (bitcnt == CW'(cfg_delay - 1'b1)) begin
                        state_n  = ST_DATA;
                        bitcnt_n = '0;
                    end else begin
                        bitcnt_n = bitcnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    shift_en  = 1'b1;
                    shift_clr = (bitcnt == '0);
                    if (bitcnt == CW'(cfg_dlen_m1)) begin
                        word_done = 1'b1;
                        bitcnt_n  = '0;
                        if (wordcnt == cfg_nwords_m1) state_n = ST_IDLE;
                        else                          wordcnt_n = wordcnt + 1'b1;
                    end else begin
                        bitcnt_n = bitcnt + 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            wordcnt <= '0;
        end else begin
            state   <= state_n;
            bitcnt  <= bitcnt_n;
            wordcnt <= wordcnt_n;
        end
    end
endmodule

// File: rtl/frame_sync_rx.sv
module frame_sync_rx
    import frame_sync_rx_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DLY_W = 8,
    parameter int NW_W  = 4,
    localparam int LEN_W = $clog2(DW)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_en,
    input  logic                rf_in,
    input  logic                rd_in,
    input  logic                cfg_start_fall,
    input  logic                cfg_sync_fall,
    input  logic                cfg_msb_first,
    input  logic [DLY_W-1:0]    cfg_delay,
    input  logic [LEN_W-1:0]    cfg_dlen_m1,
    input  logic [NW_W-1:0]     cfg_nwords_m1,
    input  logic [SL_W-1:0]     cfg_synclen_m1,
    input  logic                data_ack,
    input  logic                stat_clr,
    output logic [DW-1:0]       data_out,
    output logic                data_valid,
    output logic [SYNC_MAX-1:0] sync_tag,
    output logic                sync_tag_new,
    output logic                sync_flag,
    output logic                overrun,
    output logic                busy
);
    localparam int SH_W = max_int(DW, SYNC_MAX);
    localparam int IW   = $clog2(SH_W);

    rf_evt_t         evt;
    logic            shift_en, shift_clr, phase_sync, tag_done, word_done;
    logic [IW-1:0]   len_m1;
    logic [SH_W-1:0] sh_next;

    fsr_edge i_edge (
        .clk       (clk),
        .rst       (rst),
        .tick      (bclk_en),
        .rf_in     (rf_in),
        .start_fall(cfg_start_fall),
        .sync_fall (cfg_sync_fall),
        .stat_clr  (stat_clr),
        .evt       (evt),
        .sync_flag (sync_flag)
    );

    fsr_ctrl #(.DLY_W(DLY_W), .LEN_W(LEN_W), .NW_W(NW_W)) i_ctrl (
        .clk           (clk),
        .rst           (rst),
        .tick          (bclk_en),
        .start_evt     (evt.start),
        .cfg_delay     (cfg_delay),
        .cfg_dlen_m1   (cfg_dlen_m1),
        .cfg_nwords_m1 (cfg_nwords_m1),
        .cfg_synclen_m1(cfg_synclen_m1),
        .shift_en      (shift_en),
        .shift_clr     (shift_clr),
        .phase_sync    (phase_sync),
        .tag_done      (tag_done),
        .word_done     (word_done),
        .busy          (busy)
    );

    assign len_m1 = phase_sync ? IW'(cfg_synclen_m1) : IW'(cfg_dlen_m1);

    fsr_shift #(.W(SH_W)) i_shift (
        .clk      (clk),
        .rst      (rst),
        .en       (shift_en),
        .clr      (shift_clr),
        .msb_first(cfg_msb_first),
        .len_m1   (len_m1),
        .rd       (rd_in),
        .sh_next  (sh_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out     <= '0;
            data_valid   <= 1'b0;
            overrun      <= 1'b0;
            sync_tag     <= '0;
            sync_tag_new <= 1'b0;
        end else begin
            sync_tag_new <= tag_done;
            if (tag_done) sync_tag <= sh_next[SYNC_MAX-1:0];
            if (word_done) begin
                data_out   <= sh_next[DW-1:0];
                data_valid <= 1'b1;
            end else if (data_ack) begin
                data_valid <= 1'b0;
            end
            if (word_done && data_valid && !data_ack) overrun <= 1'b1;
            else if (stat_clr)                        overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          bclk_en,
    input logic          data_ack,
    input logic          stat_clr,
    input logic          data_valid,
    input logic          overrun,
    input logic          sync_flag,
    input logic          sync_tag_new,
    input logic          busy,
    input logic [DW-1:0] data_out
);
    AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !data_ack) |=> data_valid);                       // R7

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> ($past(data_valid) && !$past(data_ack)));     // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !stat_clr) |=> overrun);                             // R8

    AST_TAG_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        sync_tag_new |-> $past(busy));                                   // R5

    AST_TAG_PULSE: assert property (@(posedge clk) disable iff (rst)
        sync_tag_new |=> !sync_tag_new);                                 // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sync_flag && !stat_clr) |=> sync_flag);                         // R6

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (!bclk_en && !sync_flag) |=> !sync_flag);                        // R6

    AST_BUSY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !bclk_en |=> $stable(busy));                                     // R10

    AST_DATA_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !bclk_en |=> $stable(data_out));                                 // R10
endmodule

bind frame_sync_rx fsr_checker #(.DW(DW)) i_fsr_checker (
    .clk         (clk),
    .rst         (rst),
    .bclk_en     (bclk_en),
    .data_ack    (data_ack),
    .stat_clr    (stat_clr),
    .data_valid  (data_valid),
    .overrun     (overrun),
    .sync_flag   (sync_flag),
    .sync_tag_new(sync_tag_new),
    .busy        (busy),
    .data_out    (data_out)
);

// File: tb/test_frame_sync_rx.sv
module test_frame_sync_rx;
    localparam int DW = 16;
    localparam int DLY_W = 8;
    localparam int NW_W = 4;
    localparam int LEN_W = $clog2(DW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk_en = 1'b0, rf_in = 1'b0, rd_in = 1'b0;
    logic cfg_start_fall = 1'b0, cfg_sync_fall = 1'b0, cfg_msb_first = 1'b1;
    logic [DLY_W-1:0] cfg_delay = '0;
    logic [LEN_W-1:0] cfg_dlen_m1 = '0;
    logic [NW_W-1:0]  cfg_nwords_m1 = '0;
    logic [3:0]       cfg_synclen_m1 = '0;
    logic data_ack = 1'b0, stat_clr = 1'b0;
    logic [DW-1:0] data_out;
    logic data_valid, sync_tag_new, sync_flag, overrun, busy;
    logic [15:0] sync_tag;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    frame_sync_rx #(.DW(DW), .DLY_W(DLY_W), .NW_W(NW_W)) i_frame_sync_rx (.*);

    // behavioural reference model
    bit m_rf_last, m_act, m_valid, m_ovr, m_flag, m_tag_new;
    int m_k, m_nw, m_scnt, m_wcnt;
    int unsigned m_sacc, m_wacc, m_data, m_tag;

    always @(posedge clk) begin
        if (rst) begin
            m_rf_last = 0; m_act = 0; m_valid = 0; m_ovr = 0; m_flag = 0;
            m_tag_new = 0; m_data = 0; m_tag = 0;
        end else begin
            bit sev, wd;
            int dl, ln, dlen;
            sev = 0; wd = 0; m_tag_new = 0;
            dl = int'(cfg_delay); ln = int'(cfg_synclen_m1) + 1;
            dlen = int'(cfg_dlen_m1) + 1;
            if (bclk_en) begin
                bit rise, fall, stv;
                rise = rf_in && !m_rf_last;
                fall = !rf_in && m_rf_last;
                m_rf_last = rf_in;
                sev = cfg_sync_fall ? fall : rise;
                stv = cfg_start_fall ? fall : rise;
                if (m_act) begin
                    m_k++;
                    if (ln <= dl && m_k <= ln) begin
                        if (cfg_msb_first) m_sacc = (m_sacc << 1) | int'(rd_in);
                        else               m_sacc = m_sacc | (int'(rd_in) << m_scnt);
                        m_scnt++;
                        if (m_k == ln) begin m_tag = m_sacc; m_tag_new = 1; end
                    end
                    if (m_k > dl) begin
                        if (cfg_msb_first) m_wacc = (m_wacc << 1) | int'(rd_in);
                        else               m_wacc = m_wacc | (int'(rd_in) << m_wcnt);
                        m_wcnt++;
                        if (m_wcnt == dlen) begin
                            wd = 1;
                            m_nw++;
                            if (m_nw == int'(cfg_nwords_m1) + 1) m_act = 0;
                        end
                    end
                end else if (stv) begin
                    m_act = 1; m_k = 0; m_nw = 0; m_scnt = 0; m_sacc = 0;
                    m_wcnt = 0; m_wacc = 0;
                end
            end
            if (sev) m_flag = 1; else if (stat_clr) m_flag = 0;
            if (wd && m_valid && !data_ack) m_ovr = 1; else if (stat_clr) m_ovr = 0;
            if (wd) begin
                m_valid = 1; m_data = m_wacc; m_wcnt = 0; m_wacc = 0;
            end else if (data_ack) m_valid = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            chk("R9 busy at reset", int'(busy), 0);
            chk("R9 data_valid at reset", int'(data_valid), 0);
            chk("R9 flags at reset", int'({sync_flag, overrun, sync_tag_new}), 0);
            chk("R9 registers at reset", int'(data_out) | int'(sync_tag), 0);
        end else if (!finished) begin
            chk("R1/R3 busy", int'(busy), int'(m_act));
            chk("R2/R4/R10 data_out", int'(data_out), int'(m_data));
            chk("R7 data_valid", int'(data_valid), int'(m_valid));
            chk("R8 overrun", int'(overrun), int'(m_ovr));
            chk("R5 sync_tag", int'(sync_tag), int'(m_tag));
            chk("R5 sync_tag_new", int'(sync_tag_new), int'(m_tag_new));
            chk("R6 sync_flag", int'(sync_flag), int'(m_flag));
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int div, ack_on, cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        for (int seg = 0; seg < 5; seg++) begin
            // change settings only while idle
            rf_in = rf_in;
            do @(negedge clk); while (busy);
            case (seg)
                0: begin cfg_start_fall = 0; cfg_sync_fall = 0; cfg_msb_first = 1;
                         cfg_delay = 5; cfg_dlen_m1 = 7; cfg_nwords_m1 = 1;
                         cfg_synclen_m1 = 2; div = 1; ack_on = 1; end
                1: begin cfg_start_fall = 1; cfg_sync_fall = 1; cfg_msb_first = 0;
                         cfg_delay = 3; cfg_dlen_m1 = 11; cfg_nwords_m1 = 2;
                         cfg_synclen_m1 = 3; div = 3; ack_on = 1; end
                2: begin cfg_start_fall = 0; cfg_sync_fall = 1; cfg_msb_first = 1;
                         cfg_delay = 0; cfg_dlen_m1 = 15; cfg_nwords_m1 = 0;
                         cfg_synclen_m1 = 0; div = 1; ack_on = 0; end
                3: begin cfg_start_fall = 1; cfg_sync_fall = 0; cfg_msb_first = 0;
                         cfg_delay = 16; cfg_dlen_m1 = 4; cfg_nwords_m1 = 3;
                         cfg_synclen_m1 = 15; div = 2; ack_on = 1; end
                default: begin cfg_start_fall = 0; cfg_sync_fall = 0; cfg_msb_first = 0;
                         cfg_delay = 8; cfg_dlen_m1 = 0; cfg_nwords_m1 = 5;
                         cfg_synclen_m1 = 7; div = 1; ack_on = 1; end
            endcase
            for (int i = 0; i < 3000; i++) begin
                cyc++;
                bclk_en  = ((cyc % div) == 0);
                rd_in    = 1'($urandom);
                if (($urandom % 20) == 0) rf_in = ~rf_in;
                data_ack = (ack_on != 0) && (($urandom % 4) == 0);
                stat_clr = (($urandom % 16) == 0);
                @(negedge clk);
            end
            bclk_en = 1'b0; data_ack = 1'b0; stat_clr = 1'b0;
            // let any open frame drain with ticks but a quiet sync line
            for (int i = 0; i < 400 && busy; i++) begin
                bclk_en = 1'b1;
                rd_in = 1'($urandom);
                @(negedge clk);
            end
            bclk_en = 1'b0;
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule